// File: doc/BRIEF.md
# Serial Sampling Converter Reader

This block is the host side of a link to a single 8-bit serial analog-to-digital converter. It drives the converter's active-low chip select and serial clock, and reads the converter's data line. The serial clock comes from the system clock through a fixed divider. Each read is a 16-clock frame. The data line is sampled on rising serial clock edges, and the 8 result bits are taken from a fixed window inside the frame. A one-cycle valid strobe announces the result, and the result is held until the next one.

Two policies are selected per request by a low-power input, which is sampled when the request starts:
- **Continuous policy.** The block runs one full frame. The converter stays in normal mode.
- **Power-saving policy.** The block first runs a short wake frame, cut after a set falling edge. It then waits out the converter's power-up time, runs a full frame, and ends with another cut frame that puts the converter back into shutdown.

Between frames, chip select is held high for at least a quiet time. The serial clock only starts a set number of system cycles after chip select falls. A request that arrives while a sequence is running is remembered, and it starts once the current sequence has finished its quiet time. All timing counts are parameters in system clock cycles, checked at elaboration against the converter's limits.

Top module: `adc_frame_reader`

## Requirements
- R1: The serial clock is high whenever chip select is high. While chip select is low, each serial clock phase lasts exactly HALF_DIV system cycles (3 by default, about 8.3 MHz from 50 MHz). Elaboration rejects dividers that give a rate outside 4 to 10 MHz.
- R2: After chip select falls, the first serial clock edge comes no sooner than SETUP_CYC system cycles later, and it is a falling edge.
- R3: A full frame has exactly FRAME_LEN (16) falling edges and 16 rising edges with chip select low. Chip select is then raised.
- R4: The result is built from the data line sampled at rising edges 4 through 11 of the frame, counted from 1. Edge 4 gives the most significant bit. Values on the data line at all other rising edges do not affect the result.
- R5: After each full frame, sample_valid_o is high for exactly one system cycle. sample_o changes only in that cycle and holds its value otherwise.
- R6: Chip select stays high for at least QUIET_CYC system cycles between any two frames.
- R7: Under the power-saving policy, one request produces three frames. The first is a wake frame: chip select rises after its 5th falling edge, before a 6th, so it has 4 rising edges. Then chip select stays high for at least PWRUP_CYC cycles. Then comes a full frame, then a shutdown frame cut the same way as the wake frame. Exactly one valid strobe is produced.
- R8: Requests that arrive while busy are merged into one pending request. That request is served after the running sequence and its quiet time.
- R9: busy_o is high from the cycle after an accepted request until the sequence ends. While busy_o is low, chip select is high. sample_valid_o only pulses while busy_o is high.
- R10: After reset: chip select high, serial clock high, sample_valid_o low, busy_o low.
- R11: low_power_i is sampled only when a sequence starts. Changing it during a sequence does not change that sequence's frame count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request for one sampling sequence |
| low_power_i | input | 1 | 1 selects the power-saving policy for the next sequence |
| miso_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low converter chip select |
| sclk_o | output | 1 | Serial clock to the converter |
| sample_valid_o | output | 1 | One-cycle strobe marking a new result |
| sample_o | output | DATA_W | Latest result, most significant bit first on the wire |
| busy_o | output | 1 | A sampling sequence is running |

## Verification
The assertions check these properties on every cycle:
- The serial clock idles high outside frames.
- The setup delay before the first edge is respected.
- No frame has more than 16 falling edges.
- The quiet time between frames is respected.
- The valid strobe lasts one cycle, and the result holds between strobes.
- Chip select and the valid strobe stay inside busy periods.

Only the bench's scenarios can show the behaviours that depend on frame content and sequence order:
- the exact serial clock phase length;
- which rising edges form the result, and that the other bits are ignored;
- the three-frame power-saving order with its power-up gap;
- the merging of pending requests;
- the sampling of the policy input only at the start of a sequence.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SETUP,
      ST_CLOCK,
      ST_GAP
   } seq_state_t;

   typedef enum logic [1:0] {
      FR_WAKE,
      FR_FULL,
      FR_SLEEP,
      FR_NONE
   } frame_kind_t;

   // converter limits the parameters are checked against
   localparam longint SCLK_MIN_HZ   = 64'd4_000_000;
   localparam longint SCLK_MAX_HZ   = 64'd10_000_000;
   localparam int     QUIET_MIN_NS = 50;
   localparam int     PWRUP_MIN_NS = 1000;
   localparam int     SETUP_MIN_NS = 10;
   localparam int     CUT_MIN_FALL = 2;
   localparam int     CUT_MAX_FALL = 9;
   localparam int     KEEP_NORMAL_FALLS = 10;

   // true when cyc system cycles at hz last at least ns nanoseconds
   function automatic bit covers_ns(input int cyc, input int hz, input int ns);
      return (longint'(cyc) * 64'd1_000_000_000) >= (longint'(ns) * longint'(hz));
   endfunction

endpackage

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
   parameter int HALF_DIV = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic sclk_o,
   output logic fall_o,
   output logic rise_o
);

   localparam int CNT_W = $clog2(HALF_DIV + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

   logic [CNT_W-1:0] div_q;

   // strobes are high in the cycle right after the serial clock changed
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         sclk_o <= 1'b1;
         fall_o <= 1'b0;
         rise_o <= 1'b0;
      end else if (!run_i) begin
         div_q  <= '0;
         sclk_o <= 1'b1;
         fall_o <= 1'b0;
         rise_o <= 1'b0;
      end else if (div_q == CNT_LAST) begin
         div_q  <= '0;
         sclk_o <= ~sclk_o;
         fall_o <= sclk_o;
         rise_o <= ~sclk_o;
      end else begin
         div_q  <= div_q + 1'b1;
         fall_o <= 1'b0;
         rise_o <= 1'b0;
      end
   end

endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
   parameter int DATA_W    = 8,
   parameter int FRAME_LEN = 16,
   parameter int FIRST_POS = 4,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_i,
   input  logic              rise_i,
   input  logic              miso_i,
   input  logic              latch_i,
   output logic [DATA_W-1:0] data_o,
   output logic              valid_o
);

   localparam int POS_W = $clog2(FRAME_LEN + 1);
   localparam logic [POS_W-1:0] WIN_LO = POS_W'(FIRST_POS - 1);
   localparam logic [POS_W-1:0] WIN_HI = POS_W'(FIRST_POS + DATA_W - 2);

   logic [POS_W-1:0]  pos_q;
   logic [DATA_W-1:0] shreg_q;
   logic [DATA_W-1:0] shift_next;
   logic              in_window;

   assign in_window = (pos_q >= WIN_LO) && (pos_q <= WIN_HI);

   generate
      if (MSB_FIRST) begin : g_msb_first
         assign shift_next = {shreg_q[DATA_W-2:0], miso_i};
      end else begin : g_lsb_first
         assign shift_next = {miso_i, shreg_q[DATA_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q   <= '0;
         shreg_q <= '0;
      end else if (cs_n_i) begin
         pos_q <= '0;
      end else if (rise_i) begin
         pos_q <= pos_q + 1'b1;
         if (in_window) shreg_q <= shift_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= latch_i;
         if (latch_i) data_o <= shreg_q;
      end
   end

endmodule

// File: rtl/adc_rd_sequencer.sv
module adc_rd_sequencer
   import adc_rd_pkg::*;
#(
   parameter int FRAME_LEN = 16,
   parameter int CUT_FALL  = 5,
   parameter int SETUP_CYC = 1,
   parameter int QUIET_CYC = 3,
   parameter int PWRUP_CYC = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic low_power_i,
   input  logic fall_i,
   input  logic rise_i,
   output logic cs_n_o,
   output logic run_o,
   output logic latch_o,
   output logic busy_o
);

   localparam int WAIT_MAX = (PWRUP_CYC > QUIET_CYC) ?
                             ((PWRUP_CYC > SETUP_CYC) ? PWRUP_CYC : SETUP_CYC) :
                             ((QUIET_CYC > SETUP_CYC) ? QUIET_CYC : SETUP_CYC);
   localparam int WAIT_W = $clog2(WAIT_MAX + 1);
   localparam int EDGE_W = $clog2(FRAME_LEN + 1);
   localparam logic [WAIT_W-1:0] SETUP_LOAD = WAIT_W'(SETUP_CYC - 1);
   localparam logic [WAIT_W-1:0] QUIET_LOAD = WAIT_W'(QUIET_CYC - 1);
   localparam logic [WAIT_W-1:0] PWRUP_LOAD = WAIT_W'(PWRUP_CYC - 1);
   localparam logic [EDGE_W-1:0] CUT_LAST   = EDGE_W'(CUT_FALL - 1);
   localparam logic [EDGE_W-1:0] FULL_LAST  = EDGE_W'(FRAME_LEN - 1);

   seq_state_t        state_q;
   frame_kind_t       kind_q;
   frame_kind_t       next_kind;
   logic              lp_q;
   logic              pend_q;
   logic              cs_n_q;
   logic [WAIT_W-1:0] wait_q;
   logic [EDGE_W-1:0] falls_q;
   logic [EDGE_W-1:0] rises_q;
   logic              cut_hit;
   logic              full_hit;
   logic              frame_end;

   assign cut_hit   = fall_i && (kind_q != FR_FULL) && (falls_q == CUT_LAST);
   assign full_hit  = rise_i && (kind_q == FR_FULL) && (rises_q == FULL_LAST);
   assign frame_end = (state_q == ST_CLOCK) && (cut_hit || full_hit);

   // clock stops in the same cycle chip select is raised
   assign run_o   = (state_q == ST_CLOCK) && !frame_end;
   assign latch_o = frame_end && (kind_q == FR_FULL);
   assign busy_o  = (state_q != ST_IDLE);
   assign cs_n_o  = cs_n_q;

   always_comb begin
      unique case (kind_q)
         FR_WAKE: next_kind = FR_FULL;
         FR_FULL: next_kind = lp_q ? FR_SLEEP : FR_NONE;
         default: next_kind = FR_NONE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         kind_q  <= FR_NONE;
         lp_q    <= 1'b0;
         pend_q  <= 1'b0;
         cs_n_q  <= 1'b1;
         wait_q  <= '0;
         falls_q <= '0;
         rises_q <= '0;
      end else begin
         if (start_i && (state_q != ST_IDLE)) pend_q <= 1'b1;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i || pend_q) begin
                  pend_q  <= 1'b0;
                  lp_q    <= low_power_i;
                  kind_q  <= low_power_i ? FR_WAKE : FR_FULL;
                  cs_n_q  <= 1'b0;
                  wait_q  <= SETUP_LOAD;
                  state_q <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               if (wait_q == '0) begin
                  falls_q <= '0;
                  rises_q <= '0;
                  state_q <= ST_CLOCK;
               end else begin
                  wait_q <= wait_q - 1'b1;
               end
            end
            ST_CLOCK: begin
               if (frame_end) begin
                  cs_n_q  <= 1'b1;
                  wait_q  <= (kind_q == FR_WAKE) ? PWRUP_LOAD : QUIET_LOAD;
                  kind_q  <= next_kind;
                  state_q <= ST_GAP;
               end else begin
                  if (fall_i) falls_q <= falls_q + 1'b1;
                  if (rise_i) rises_q <= rises_q + 1'b1;
               end
            end
            ST_GAP: begin
               if (wait_q != '0) begin
                  wait_q <= wait_q - 1'b1;
               end else if (kind_q == FR_NONE) begin
                  state_q <= ST_IDLE;
               end else begin
                  cs_n_q  <= 1'b0;
                  wait_q  <= SETUP_LOAD;
                  state_q <= ST_SETUP;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
   import adc_rd_pkg::*;
#(
   parameter int SYS_CLK_HZ = 50_000_000,
   parameter int DATA_W     = 8,
   parameter int FRAME_LEN  = 16,
   parameter int FIRST_POS  = 4,
   parameter bit MSB_FIRST  = 1'b1,
   parameter int HALF_DIV   = 3,
   parameter int CUT_FALL   = 5,
   parameter int SETUP_CYC  = 1,
   parameter int QUIET_CYC  = 3,
   parameter int PWRUP_CYC  = 50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              low_power_i,
   input  logic              miso_i,
   output logic              cs_n_o,
   output logic              sclk_o,
   output logic              sample_valid_o,
   output logic [DATA_W-1:0] sample_o,
   output logic              busy_o
);

   localparam longint SCLK_HZ = longint'(SYS_CLK_HZ) / longint'(2 * HALF_DIV);

   generate
      if (HALF_DIV < 2 || SCLK_HZ < SCLK_MIN_HZ || SCLK_HZ > SCLK_MAX_HZ) begin : g_bad_div
         $error("serial clock divider gives a rate outside the converter range");
      end
      if (!covers_ns(SETUP_CYC, SYS_CLK_HZ, SETUP_MIN_NS) || SETUP_CYC < 1) begin : g_bad_setup
         $error("chip select to clock setup too short");
      end
      if (!covers_ns(QUIET_CYC, SYS_CLK_HZ, QUIET_MIN_NS) || QUIET_CYC < 1) begin : g_bad_quiet
         $error("quiet time too short");
      end
      if (!covers_ns(PWRUP_CYC, SYS_CLK_HZ, PWRUP_MIN_NS) || PWRUP_CYC < QUIET_CYC) begin : g_bad_pwrup
         $error("power-up wait too short");
      end
      if (CUT_FALL < CUT_MIN_FALL || CUT_FALL > CUT_MAX_FALL) begin : g_bad_cut
         $error("cut edge outside the shutdown window");
      end
      if (FRAME_LEN < KEEP_NORMAL_FALLS || DATA_W < 2 ||
          FIRST_POS < 1 || FIRST_POS + DATA_W - 1 > FRAME_LEN) begin : g_bad_frame
         $error("frame length or data window inconsistent");
      end
   endgenerate

   logic run;
   logic fall_stb;
   logic rise_stb;
   logic latch;
   logic cs_n;

   adc_rd_sclk_gen #(
      .HALF_DIV (HALF_DIV)
   ) u_sclk (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run),
      .sclk_o (sclk_o),
      .fall_o (fall_stb),
      .rise_o (rise_stb)
   );

   adc_rd_sequencer #(
      .FRAME_LEN (FRAME_LEN),
      .CUT_FALL  (CUT_FALL),
      .SETUP_CYC (SETUP_CYC),
      .QUIET_CYC (QUIET_CYC),
      .PWRUP_CYC (PWRUP_CYC)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .low_power_i (low_power_i),
      .fall_i      (fall_stb),
      .rise_i      (rise_stb),
      .cs_n_o      (cs_n),
      .run_o       (run),
      .latch_o     (latch),
      .busy_o      (busy_o)
   );

   adc_rd_capture #(
      .DATA_W    (DATA_W),
      .FRAME_LEN (FRAME_LEN),
      .FIRST_POS (FIRST_POS),
      .MSB_FIRST (MSB_FIRST)
   ) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n_i  (cs_n),
      .rise_i  (rise_stb),
      .miso_i  (miso_i),
      .latch_i (latch),
      .data_o  (sample_o),
      .valid_o (sample_valid_o)
   );

   assign cs_n_o = cs_n;

endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
   parameter int DATA_W    = 8,
   parameter int FRAME_LEN = 16,
   parameter int SETUP_CYC = 1,
   parameter int QUIET_CYC = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n_o,
   input logic              sclk_o,
   input logic              sample_valid_o,
   input logic [DATA_W-1:0] sample_o,
   input logic              busy_o
);

   localparam int HI_W = $clog2(QUIET_CYC + 2);
   localparam int LO_W = $clog2(SETUP_CYC + 2);
   localparam int FC_W = $clog2(FRAME_LEN + 2);

   logic [HI_W-1:0] hi_cnt;
   logic [LO_W-1:0] lo_cnt;
   logic [FC_W-1:0] fall_cnt;
   logic            sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt   <= HI_W'(QUIET_CYC);
         lo_cnt   <= '0;
         fall_cnt <= '0;
         sclk_q   <= 1'b1;
      end else begin
         sclk_q <= sclk_o;
         if (!cs_n_o) hi_cnt <= '0;
         else if (hi_cnt < HI_W'(QUIET_CYC)) hi_cnt <= hi_cnt + 1'b1;
         if (cs_n_o) lo_cnt <= '0;
         else if (lo_cnt < LO_W'(SETUP_CYC)) lo_cnt <= lo_cnt + 1'b1;
         if (cs_n_o) fall_cnt <= '0;
         else if (sclk_q && !sclk_o && fall_cnt < FC_W'(FRAME_LEN + 1)) fall_cnt <= fall_cnt + 1'b1;
      end
   end

   assert_sclk_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> sclk_o);

   assert_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_o && $fell(sclk_o)) |-> (lo_cnt >= LO_W'(SETUP_CYC)));

   assert_frame_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fall_cnt <= FC_W'(FRAME_LEN));

   assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid_o |=> !sample_valid_o);

   assert_sample_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_valid_o |-> $stable(sample_o));

   assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_o) |-> (hi_cnt >= HI_W'(QUIET_CYC)));

   assert_idle_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> cs_n_o);

   assert_valid_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid_o |-> busy_o);

endmodule

bind adc_frame_reader adc_frame_reader_chk #(
   .DATA_W    (DATA_W),
   .FRAME_LEN (FRAME_LEN),
   .SETUP_CYC (SETUP_CYC),
   .QUIET_CYC (QUIET_CYC)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cs_n_o         (cs_n_o),
   .sclk_o         (sclk_o),
   .sample_valid_o (sample_valid_o),
   .sample_o       (sample_o),
   .busy_o         (busy_o)
);

// File: tb/adc_frame_reader_test.sv
`timescale 1ns/1ps
module adc_frame_reader_test;

   localparam int HALF  = 3;
   localparam int SETUP = 1;
   localparam int QUIET = 3;
   localparam int PWRUP = 50;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       low_power_i = 1'b0;
   logic       miso_i = 1'b1;
   logic       cs_n_o;
   logic       sclk_o;
   logic       sample_valid_o;
   logic [7:0] sample_o;
   logic       busy_o;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   adc_frame_reader #(
      .HALF_DIV  (HALF),
      .SETUP_CYC (SETUP),
      .QUIET_CYC (QUIET),
      .PWRUP_CYC (PWRUP)
   ) uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (start_i),
      .low_power_i    (low_power_i),
      .miso_i         (miso_i),
      .cs_n_o         (cs_n_o),
      .sclk_o         (sclk_o),
      .sample_valid_o (sample_valid_o),
      .sample_o       (sample_o),
      .busy_o         (busy_o)
   );

   // converter model: bit for rising edge k is word[16-k], driven after falling edge k
   logic [15:0] word = 16'hFFFF;
   int          bidx = 0;
   always @(negedge cs_n_o) begin
      bidx   = 0;
      miso_i = 1'b1;
   end
   always @(negedge sclk_o) begin
      if (!cs_n_o) begin
         bidx = bidx + 1;
         if (bidx <= 16) miso_i = word[16-bidx];
      end
   end

   // port monitor, sampled away from the active edge
   int frames, cur_falls, cur_rises, since_cs, ph_len, hi_run;
   int half_min, half_max, setup_min, valid_cnt;
   bit valid_wide, seen_edge;
   int falls_log [8];
   int rises_log [8];
   int gap_log [8];
   logic prev_cs = 1'b1, prev_sclk = 1'b1, prev_valid = 1'b0;

   task automatic clear_mon();
      frames = 0; half_min = 1000; half_max = 0; setup_min = 1000;
      valid_cnt = 0; valid_wide = 0;
      for (int i = 0; i < 8; i++) begin
         falls_log[i] = 0; rises_log[i] = 0; gap_log[i] = 0;
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (!cs_n_o) begin
            if (prev_cs) begin
               if (frames < 8) gap_log[frames] = hi_run;
               frames++; cur_falls = 0; cur_rises = 0; since_cs = 0;
               ph_len = 0; seen_edge = 0;
            end else begin
               since_cs++;
               ph_len++;
               if (sclk_o != prev_sclk) begin
                  if (!seen_edge && since_cs < setup_min) setup_min = since_cs;
                  if (seen_edge) begin
                     if (ph_len < half_min) half_min = ph_len;
                     if (ph_len > half_max) half_max = ph_len;
                  end
                  if (!sclk_o) cur_falls++; else cur_rises++;
                  ph_len = 0; seen_edge = 1;
               end
            end
         end else begin
            if (!prev_cs && frames >= 1 && frames <= 8) begin
               falls_log[frames-1] = cur_falls;
               rises_log[frames-1] = cur_rises;
               hi_run = 0;
            end
            hi_run++;
         end
         if (sample_valid_o) begin
            valid_cnt++;
            if (prev_valid) valid_wide = 1;
         end
      end
      prev_cs = cs_n_o; prev_sclk = sclk_o; prev_valid = sample_valid_o;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
   endtask

   task automatic wait_quiet(input string req);
      int idle_run = 0;
      int n = 0;
      while (idle_run < 10 && n < 20000) begin
         @(negedge clk); n++;
         if (!busy_o) idle_run++; else idle_run = 0;
      end
      chk(idle_run >= 10, req, "sequence finishes", idle_run, 10);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(cs_n_o == 1'b1, "R10", "cs_n after reset", cs_n_o, 1);
      chk(sclk_o == 1'b1, "R10", "sclk after reset", sclk_o, 1);
      chk(sample_valid_o == 1'b0, "R10", "valid after reset", sample_valid_o, 0);
      chk(busy_o == 1'b0, "R10", "busy after reset", busy_o, 0);
   endtask

   // one continuous-policy read; lp_flip raises low_power_i mid-sequence (R11)
   task automatic t_normal(input logic [7:0] d, input logic [2:0] lead,
                           input logic [4:0] trail, input bit lp_flip);
      clear_mon();
      word = {lead, d, trail};
      low_power_i = 1'b0;
      pulse_start();
      chk(busy_o == 1'b1, "R9", "busy after start", busy_o, 1);
      if (lp_flip) begin
         repeat (20) @(negedge clk);
         low_power_i = 1'b1;
      end
      wait_quiet("R3");
      low_power_i = 1'b0;
      chk(sample_o == d, "R4", "result byte", sample_o, d);
      chk(frames == 1, lp_flip ? "R11" : "R3", "frame count", frames, 1);
      chk(falls_log[0] == 16, "R3", "falling edges", falls_log[0], 16);
      chk(rises_log[0] == 16, "R3", "rising edges", rises_log[0], 16);
      chk(half_min == HALF && half_max == HALF, "R1", "sclk phase", half_max, HALF);
      chk(setup_min >= SETUP, "R2", "cs to first edge", setup_min, SETUP);
      chk(valid_cnt == 1, "R5", "valid pulses", valid_cnt, 1);
      chk(!valid_wide, "R5", "valid width over 1", valid_wide, 0);
      chk(cs_n_o && sclk_o, "R1", "idle lines high", {cs_n_o, sclk_o}, 3);
   endtask

   task automatic t_lowpower(input logic [7:0] d);
      clear_mon();
      word = {3'b101, d, 5'b10110};
      low_power_i = 1'b1;
      pulse_start();
      repeat (5) @(negedge clk);
      low_power_i = 1'b0;
      wait_quiet("R7");
      chk(frames == 3, "R7", "frames in power-saving sequence", frames, 3);
      chk(falls_log[0] == 5 && rises_log[0] == 4, "R7", "wake frame falls", falls_log[0], 5);
      chk(falls_log[1] == 16, "R7", "full frame falls", falls_log[1], 16);
      chk(falls_log[2] == 5 && rises_log[2] == 4, "R7", "shutdown frame falls", falls_log[2], 5);
      chk(gap_log[1] >= PWRUP, "R7", "power-up gap", gap_log[1], PWRUP);
      chk(gap_log[2] >= QUIET, "R6", "quiet before shutdown frame", gap_log[2], QUIET);
      chk(sample_o == d, "R7", "power-saving result", sample_o, d);
      chk(valid_cnt == 1, "R7", "valid pulses", valid_cnt, 1);
      chk(half_min == HALF && half_max == HALF, "R1", "sclk phase in cut frames", half_min, HALF);
   endtask

   task automatic t_pending(input logic [7:0] d);
      clear_mon();
      word = {3'b000, d, 5'b00000};
      low_power_i = 1'b0;
      pulse_start();
      repeat (20) @(negedge clk);
      pulse_start();
      repeat (7) @(negedge clk);
      pulse_start();
      wait_quiet("R8");
      chk(frames == 2, "R8", "merged requests give two frames", frames, 2);
      chk(valid_cnt == 2, "R8", "valid pulses", valid_cnt, 2);
      chk(gap_log[1] >= QUIET, "R6", "quiet between frames", gap_log[1], QUIET);
      chk(sample_o == d, "R4", "pending result", sample_o, d);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      clear_mon();
      cur_falls = 0; cur_rises = 0; since_cs = 0; ph_len = 0; hi_run = 100; seen_edge = 0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_normal(8'hA5, 3'b111, 5'b11111, 1'b0);
      t_normal(8'h00, 3'b111, 5'b11111, 1'b0);
      t_normal(8'hFF, 3'b000, 5'b00000, 1'b0);
      t_normal(8'h81, 3'b010, 5'b01010, 1'b1);
      t_lowpower(8'h3C);
      t_normal(8'h5A, 3'b101, 5'b10101, 1'b0);
      t_pending(8'hC3);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule